// File: doc/BRIEF.md
# FIFO Fill-Level Crossing Interrupt Trigger

This block sits next to a pair of byte queues in a serial port, one holding received characters and one holding characters waiting to be sent. It watches the two occupancy counts and raises a sticky status bit when a count crosses a programmed level in the direction that matters. For the receive queue that direction is filling. For the transmit queue it is draining. A status bit fires only on the exact one-step change onto the selected level. A count that merely sits at or beyond the level does not fire it, and neither does a count that jumps over the level.

Each queue has its own 3-bit level code. Software arms the interrupt through a mask and acknowledges it with a write-one-to-clear strobe. The status vector is six bits wide: bit 4 belongs to the receive queue and bit 5 to the transmit queue. Bits 0 to 3 are never set. All pins are plain control and status pins, so the block has no valid/ready handshake and applies no back-pressure.

Top module: `fifo_level_irq`

## Requirements
- R1: While reset is held and on the first cycle after it, `raw_status`, `masked_status` and `irq` are all zero.
- R2: The receive bit (status bit 4) sets when `rx_level` steps up by exactly one onto the selected level. For a depth of 16, `rx_sel` code 0 means 1→2, code 1 means 3→4, code 2 means 7→8, code 3 means 11→12 and code 4 means 13→14.
- R3: The transmit bit (status bit 5) sets when `tx_level` steps down by exactly one onto the selected level. For a depth of 16, `tx_sel` code 0 means 15→14, code 1 means 13→12, code 2 means 9→8, code 3 means 5→4 and code 4 means 3→2.
- R4: None of the following sets a status bit: a step in the opposite direction, a jump of more than one count that lands on the level, or a count that holds at the level.
- R5: Codes 5, 6 and 7 never set the status bit of their queue.
- R6: A set status bit stays set while no acknowledge hits it, even after the level moves back across the threshold.
- R7: When `ack_wr` is high, each 1 in `ack_bits` clears the matching status bit at that clock edge. A 0 in `ack_bits` has no effect, and `ack_bits` is ignored while `ack_wr` is low.
- R8: When a set condition and an acknowledge of the same bit meet in one cycle, the bit ends set.
- R9: `masked_status` equals `raw_status` ANDed bitwise with `irq_mask`, where bit 4 arms the receive interrupt and bit 5 arms the transmit interrupt.
- R10: `irq` is high exactly when any bit of `masked_status` is high.
- R11: A level change on the inputs appears in `raw_status` after the next rising clock edge, with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_level | input | CW (5) | Receive queue occupancy, 0 to DEPTH |
| tx_level | input | CW (5) | Transmit queue occupancy, 0 to DEPTH |
| rx_sel | input | 3 | Receive crossing level code |
| tx_sel | input | 3 | Transmit crossing level code |
| irq_mask | input | 6 | Per-bit interrupt arm |
| ack_wr | input | 1 | Acknowledge write strobe |
| ack_bits | input | 6 | Write-one-to-clear data |
| raw_status | output | 6 | Sticky raw status |
| masked_status | output | 6 | Raw status gated by mask |
| irq | output | 1 | Combined interrupt line |

## Verification
The hardest case to reach from the ports is the exact single-step crossing that matches the current code. It has to coincide with an acknowledge of the same bit, or arrive after a multi-count jump that has to be rejected. A free random walk rarely lines these up with the right code. Directed sequences therefore march each level up and down through every code, and they place an acknowledge on the crossing cycle. The random walk mixes single steps, holds and two-count jumps with random codes, masks and acknowledges. It is scored cycle by cycle against a bench model of the crossing table.

// File: rtl/fifo_lvl_pkg.sv
package fifo_lvl_pkg;

  localparam int STS_W   = 6;
  localparam int RX_BIT  = 4;
  localparam int TX_BIT  = 5;
  localparam int CODE_MAX = 4;

  // Codes above CODE_MAX are reserved and never match.
  function automatic bit code_ok(input logic [2:0] code);
    return int'(code) <= CODE_MAX;
  endfunction

  // Fill threshold in eighths of the queue depth.
  function automatic int fill_eighths(input logic [2:0] code);
    case (code)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 6;
      default: return 7;
    endcase
  endfunction

  // Level the count must land on; draining queues mirror the filling ones.
  function automatic int trig_level(input int depth, input logic [2:0] code,
                                    input bit rising);
    int fill;
    fill = depth * fill_eighths(code) / 8;
    return rising ? fill : depth - fill;
  endfunction

endpackage

// File: rtl/fifo_lvl_cross.sv
module fifo_lvl_cross #(
  parameter int DEPTH  = 16,
  parameter int CW     = 5,
  parameter bit RISING = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] level,
  input  logic [2:0]    sel,
  output logic          hit
);
  import fifo_lvl_pkg::*;

  logic [CW-1:0] prev_q;
  logic [CW-1:0] target;
  logic [CW-1:0] origin;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  always_comb target = CW'(trig_level(DEPTH, sel, RISING));

  generate
    if (RISING) begin : g_fill
      always_comb origin = CW'(trig_level(DEPTH, sel, RISING) - 1);
    end else begin : g_drain
      always_comb origin = CW'(trig_level(DEPTH, sel, RISING) + 1);
    end
  endgenerate

  always_comb hit = code_ok(sel) && (prev_q == origin) && (level == target);

endmodule

// File: rtl/fifo_lvl_sticky.sv
module fifo_lvl_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/fifo_level_irq.sv
module fifo_level_irq #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] rx_level,
  input  logic [CW-1:0] tx_level,
  input  logic [2:0]    rx_sel,
  input  logic [2:0]    tx_sel,
  input  logic [5:0]    irq_mask,
  input  logic          ack_wr,
  input  logic [5:0]    ack_bits,
  output logic [5:0]    raw_status,
  output logic [5:0]    masked_status,
  output logic          irq
);
  import fifo_lvl_pkg::*;

  logic rx_hit, tx_hit;
  logic [STS_W-1:0] set_vec;

  fifo_lvl_cross #(.DEPTH(DEPTH), .CW(CW), .RISING(1'b1)) u_rx_cross (
    .clk(clk), .rst_n(rst_n), .level(rx_level), .sel(rx_sel), .hit(rx_hit)
  );

  fifo_lvl_cross #(.DEPTH(DEPTH), .CW(CW), .RISING(1'b0)) u_tx_cross (
    .clk(clk), .rst_n(rst_n), .level(tx_level), .sel(tx_sel), .hit(tx_hit)
  );

  generate
    for (genvar i = 0; i < STS_W; i++) begin : g_bit
      if (i == RX_BIT) begin : g_rx
        assign set_vec[i] = rx_hit;
      end else if (i == TX_BIT) begin : g_tx
        assign set_vec[i] = tx_hit;
      end else begin : g_none
        assign set_vec[i] = 1'b0;
      end
      fifo_lvl_sticky u_flag (
        .clk(clk), .rst_n(rst_n), .set(set_vec[i]),
        .clr(ack_wr & ack_bits[i]), .q(raw_status[i])
      );
    end
  endgenerate

  always_comb begin
    masked_status = raw_status & irq_mask;
    irq           = |masked_status;
  end

endmodule

// File: rtl/fifo_level_irq_chk.sv
module fifo_level_irq_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] rx_level,
  input logic [CW-1:0] tx_level,
  input logic [2:0]    rx_sel,
  input logic [2:0]    tx_sel,
  input logic [5:0]    irq_mask,
  input logic          ack_wr,
  input logic [5:0]    ack_bits,
  input logic [5:0]    raw_status,
  input logic [5:0]    masked_status,
  input logic          irq
);
  import fifo_lvl_pkg::*;

  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_rx_cross_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && code_ok(rx_sel)
     && int'($past(rx_level)) == trig_level(DEPTH, rx_sel, 1'b1) - 1
     && int'(rx_level) == trig_level(DEPTH, rx_sel, 1'b1))
    |=> raw_status[RX_BIT]);

  assert_tx_cross_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && code_ok(tx_sel)
     && int'($past(tx_level)) == trig_level(DEPTH, tx_sel, 1'b0) + 1
     && int'(tx_level) == trig_level(DEPTH, tx_sel, 1'b0))
    |=> raw_status[TX_BIT]);

  assert_reserved_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!raw_status[RX_BIT] && !code_ok(rx_sel)) |=> !raw_status[RX_BIT]);

  assert_rx_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_status[RX_BIT] && !(ack_wr && ack_bits[RX_BIT])) |=> raw_status[RX_BIT]);

  assert_tx_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_status[TX_BIT] && !(ack_wr && ack_bits[TX_BIT])) |=> raw_status[TX_BIT]);

  assert_rx_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && ack_bits[RX_BIT] && !code_ok(rx_sel)) |=> !raw_status[RX_BIT]);

  assert_low_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    raw_status[3:0] == 4'b0000);

endmodule

bind fifo_level_irq fifo_level_irq_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/fifo_level_irq_test.sv
module fifo_level_irq_test;
  localparam int DEPTH = 16;
  localparam int CW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] rx_level = '0, tx_level = '0;
  logic [2:0] rx_sel = '0, tx_sel = '0;
  logic [5:0] irq_mask = '0, ack_bits = '0;
  logic ack_wr = 1'b0;
  logic [5:0] raw_status, masked_status;
  logic irq;

  int checks = 0, errors = 0;
  int m_rx_prev = 0, m_tx_prev = 0;
  logic [5:0] m_raw = '0;

  always #2 clk = ~clk;

  fifo_level_irq #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .tx_level(tx_level),
    .rx_sel(rx_sel), .tx_sel(tx_sel), .irq_mask(irq_mask), .ack_wr(ack_wr),
    .ack_bits(ack_bits), .raw_status(raw_status),
    .masked_status(masked_status), .irq(irq)
  );

  function automatic int rx_to(input int code);
    case (code)
      0: return 2; 1: return 4; 2: return 8; 3: return 12; 4: return 14;
      default: return -100;
    endcase
  endfunction

  function automatic int tx_to(input int code);
    case (code)
      0: return 14; 1: return 12; 2: return 8; 3: return 4; 4: return 2;
      default: return -100;
    endcase
  endfunction

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, model, then compare 1 ns after the edge.
  task automatic step(input string tag, input int rxc, input int txc,
                      input logic aw, input logic [5:0] ab);
    logic [5:0] sets, clrs;
    @(negedge clk);
    rx_level = CW'(rxc); tx_level = CW'(txc); ack_wr = aw; ack_bits = ab;
    sets = '0;
    if (rxc == rx_to(int'(rx_sel)) && m_rx_prev == rxc - 1) sets[4] = 1'b1;
    if (txc == tx_to(int'(tx_sel)) && m_tx_prev == txc + 1) sets[5] = 1'b1;
    clrs = aw ? ab : 6'b0;
    m_raw = (m_raw & ~clrs) | sets;
    m_rx_prev = rxc; m_tx_prev = txc;
    @(posedge clk); #1;
    check({tag, " raw"}, raw_status, m_raw);
    check("R9 masked", masked_status, m_raw & irq_mask);
    check("R10 irq", {5'b0, irq}, {5'b0, |(m_raw & irq_mask)});
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, m_rx_prev, m_tx_prev, 1'b0, 6'b0);
  endtask

  task automatic clear_all();
    step("R7 ack all", m_rx_prev, m_tx_prev, 1'b1, 6'b111111);
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    irq_mask = 6'b110000;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset raw", raw_status, 6'b0);
    check("R1 reset irq", {5'b0, irq}, 6'b0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 post-reset", raw_status | masked_status, 6'b0);

    // R2: every receive code, walking up from empty
    for (int c = 0; c < 5; c++) begin
      rx_sel = 3'(c);
      for (int l = 0; l <= 16; l++) step("R2 rx walk", l, 0, 1'b0, 6'b0);
      clear_all();
      step("R2 reset level", 0, 0, 1'b0, 6'b0);
    end
    // R3: every transmit code, walking down from full
    step("R3 fill", 0, 16, 1'b0, 6'b0);
    for (int c = 0; c < 5; c++) begin
      tx_sel = 3'(c);
      for (int l = 16; l >= 0; l--) step("R3 tx walk", 0, l, 1'b0, 6'b0);
      clear_all();
      step("R3 refill", 0, 16, 1'b0, 6'b0);
    end
    // R4: wrong direction, jumps, holds
    rx_sel = 3'd2; tx_sel = 3'd2;
    step("R4 setup", 9, 7, 1'b0, 6'b0);
    step("R4 rx down onto level", 8, 8, 1'b0, 6'b0);
    idle("R4 hold at level", 3);
    step("R4 jump", 6, 10, 1'b0, 6'b0);
    step("R4 jump onto level", 8, 8, 1'b0, 6'b0);
    check("R4 no set", raw_status, 6'b0);
    // R5: reserved codes
    for (int c = 5; c < 8; c++) begin
      rx_sel = 3'(c); tx_sel = 3'(c);
      for (int l = 0; l <= 16; l++) step("R5 reserved", l, 16 - l, 1'b0, 6'b0);
      check("R5 quiet", raw_status, 6'b0);
    end
    // R6 sticky, R7 zero-bit and strobe-low acks, R11 latency
    rx_sel = 3'd1; tx_sel = 3'd3;
    step("R11 pre", 3, 5, 1'b0, 6'b0);
    step("R11 one-cycle set", 4, 4, 1'b0, 6'b0);
    check("R11 both set", raw_status, 6'b110000);
    step("R6 fall back", 1, 9, 1'b0, 6'b0);
    idle("R6 hold", 4);
    step("R7 zero bits", 1, 9, 1'b1, 6'b001111);
    step("R7 strobe low", 1, 9, 1'b0, 6'b110000);
    step("R7 clear rx only", 1, 9, 1'b1, 6'b010000);
    check("R7 tx kept", raw_status, 6'b100000);
    // R8 set wins over ack
    step("R8 pre", 3, 5, 1'b0, 6'b0);
    step("R8 set beats ack", 4, 4, 1'b1, 6'b110000);
    check("R8 both held", raw_status, 6'b110000);
    // R9/R10 masking
    irq_mask = 6'b010000; idle("R9 rx arm only", 1);
    irq_mask = 6'b100000; idle("R9 tx arm only", 1);
    irq_mask = 6'b001111; idle("R10 no armed bit", 1);
    clear_all();

    // Random walk
    for (int n = 0; n < 4000; n++) begin
      int r, t, d;
      logic aw;
      if ($urandom % 16 == 0) begin
        rx_sel = 3'($urandom % 8); tx_sel = 3'($urandom % 8);
        irq_mask = 6'($urandom);
      end
      d = int'($urandom % 5); r = m_rx_prev + (d == 1 ? 1 : d == 2 ? -1 : d == 3 ? 2 : d == 4 ? -2 : 0);
      d = int'($urandom % 5); t = m_tx_prev + (d == 1 ? 1 : d == 2 ? -1 : d == 3 ? 2 : d == 4 ? -2 : 0);
      if (r < 0) r = 0; if (r > 16) r = 16;
      if (t < 0) t = 0; if (t > 16) t = 16;
      aw = ($urandom % 6 == 0);
      step("R2 R3 R6 R7 random", r, t, aw, 6'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule